// File: doc/BRIEF.md
# Keyboard Matrix Scan Sequencer

This block walks a keyboard matrix of 8 logical columns and 16 sense rows. The scan lines sit on two 8-bit banks, and every line has its own output-enable. One column is handled at a time. The block first narrows the output drivers down to the single physical line of that column and lets the direction change settle. It then pulls that line low, holds every other line high, and after a second, longer settle it captures the 16-bit active-low sense word. The word leaves the block together with its column index.

A pass starts on a periodic tick or on a poll request, and only while the enable input is high. A request that arrives during a pass is remembered, and exactly one more pass runs afterwards. Between passes the block rests in an idle state: every scan line driven, every level high. Debouncing and key-code translation belong to the consumer of the sampled words.

The settle times are given in microseconds and turned into clock cycles through a clock-frequency parameter in MHz.

Top module: `kbd_scan_seq`

## Requirements
- R1: A pass produces exactly 8 sampled words, one each for columns 0, 1, ..., 7 in ascending order, and `keyValid` is only ever high while `busy` is high.
- R2: Logical column to physical line, written as bank/bit, where bank A is `oeBankA`/`lvlBankA` and bank B is `oeBankB`/`lvlBankB`: 0→A1, 1→A5, 2→B1, 3→B6, 4→B7, 5→B3, 6→B0, 7→A7.
- R3: Each column begins with a direction phase of DIR_US*CLK_MHZ cycles. In this phase the output-enable is 1 only on the column's line and 0 on every other line. The levels keep the values they had in the previous phase.
- R4: A level phase of LVL_US*CLK_MHZ cycles follows. In this phase the column's line is at level 0 and all other lines are at 1, and the output-enables do not change.
- R5: At the clock edge that ends a level phase, the block captures `{senseHi, senseLo}` into `keyWord` and the column into `keyCol`. `keyValid` is high for exactly the one cycle after that edge.
- R6: After column 7 there is one cycle with all levels at 1 while the output-enable remains on line A7. Only after that cycle are all scan lines driven again.
- R7: A pass starts only from `tick` or `pollReq` sampled while `enable` is 1. A request made with `enable` at 0 is dropped and is not remembered. A pass that is already running completes even if `enable` falls.
- R8: `busy` rises at the edge that applies the column 0 direction phase and falls at the edge that restores idle. Whenever `busy` is 0, the output-enables are 8'hA2 (bank A) and 8'hCB (bank B), and both level buses are 8'hFF.
- R9: One or more requests during a pass, including a request in its final cycle, start exactly one more pass. `busy` is then low for exactly one cycle between the two passes.
- R10: Bit positions that are not scan lines always have output-enable 0 and level 1.
- R11: After reset, `busy` and `keyValid` are 0, `keyWord` is 16'hFFFF, `keyCol` is 0, and the lines show the idle pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows passes to start |
| tick | input | 1 | Periodic scan request |
| pollReq | input | 1 | Explicit scan request |
| senseLo | input | 8 | Sense rows 0..7, active low |
| senseHi | input | 8 | Sense rows 8..15, active low |
| oeBankA | output | 8 | Output-enable per line, bank A (1 = driven) |
| lvlBankA | output | 8 | Drive level per line, bank A |
| oeBankB | output | 8 | Output-enable per line, bank B (1 = driven) |
| lvlBankB | output | 8 | Drive level per line, bank B |
| keyWord | output | 16 | Last sampled sense word |
| keyCol | output | 3 | Column of `keyWord` |
| keyValid | output | 1 | One-cycle strobe for a new sample |
| busy | output | 1 | High while a pass runs |

## Verification
The hardest case to reach from the ports is a request that lands in the single cycle after the last sample, when the levels are parked high but idle has not yet been restored. The stimulus reaches it by counting cycles from the start of a pass and firing `pollReq` in exactly that cycle. The bench then confirms that the idle gap is one cycle long and that only one further pass follows. The bench also models the matrix on its own side. It works out which line is driven low, decodes that line back to a column through its own copy of the map, and presents a random sense word per column. This lets it check that every capture belongs to the right column and that the line pattern is correct in every cycle of the pass.

// File: rtl/kbs_pkg.sv
package kbs_pkg;

  localparam int BANK_W   = 8;
  localparam int LINE_W   = $clog2(BANK_W);
  localparam int NUM_COLS = 8;
  localparam int COL_W    = $clog2(NUM_COLS);
  localparam int SENSE_W  = 2 * BANK_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIR,
    ST_LVL,
    ST_PARK
  } scanState_e;

  // physical line: which bank, which bit inside it
  typedef struct packed {
    logic              bank;
    logic [LINE_W-1:0] line;
  } lineSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             goDir;
    logic             goLvl;
    logic             park;
    logic             restore;
    logic             sample;
    logic [COL_W-1:0] driveCol;
    logic [COL_W-1:0] sampCol;
  } scanStrobe_t;

  // fixed wiring order of the matrix columns
  function automatic lineSel_t colToLine(input logic [COL_W-1:0] col);
    lineSel_t s;
    case (col)
      3'd0:    s = '{bank: 1'b0, line: 3'd1};
      3'd1:    s = '{bank: 1'b0, line: 3'd5};
      3'd2:    s = '{bank: 1'b1, line: 3'd1};
      3'd3:    s = '{bank: 1'b1, line: 3'd6};
      3'd4:    s = '{bank: 1'b1, line: 3'd7};
      3'd5:    s = '{bank: 1'b1, line: 3'd3};
      3'd6:    s = '{bank: 1'b1, line: 3'd0};
      default: s = '{bank: 1'b0, line: 3'd7};
    endcase
    return s;
  endfunction

  function automatic logic [BANK_W-1:0] bankMask(input logic bank);
    logic [BANK_W-1:0] m;
    lineSel_t s;
    m = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      s = colToLine(COL_W'(c));
      if (s.bank == bank) m[s.line] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [BANK_W-1:0] SCAN_MASK_A = bankMask(1'b0);
  localparam logic [BANK_W-1:0] SCAN_MASK_B = bankMask(1'b1);

endpackage

// File: rtl/kbs_ctrl.sv
module kbs_ctrl
  import kbs_pkg::*;
#(
  parameter int DIR_CYC = 1000,
  parameter int LVL_CYC = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        tick,
  input  logic        pollReq,
  output logic        busy,
  output scanStrobe_t strb
);

  localparam int MAX_CYC = (DIR_CYC > LVL_CYC) ? DIR_CYC : LVL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] DIR_LAST = CNT_W'(DIR_CYC - 1);
  localparam logic [CNT_W-1:0] LVL_LAST = CNT_W'(LVL_CYC - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  scanState_e       state, stateN;
  logic [COL_W-1:0] col, colN;
  logic [CNT_W-1:0] cnt, cntN;
  logic             pending, pendingN;
  logic             request, startNow;

  assign request = tick | pollReq;

  always_comb begin
    stateN        = state;
    colN          = col;
    cntN          = cnt;
    startNow      = 1'b0;
    strb          = '0;
    strb.driveCol = col;
    strb.sampCol  = col;
    case (state)
      ST_IDLE: begin
        if (enable && (request || pending)) begin
          stateN        = ST_DIR;
          colN          = '0;
          cntN          = '0;
          startNow      = 1'b1;
          strb.goDir    = 1'b1;
          strb.driveCol = '0;
        end
      end
      ST_DIR: begin
        if (cnt == DIR_LAST) begin
          stateN     = ST_LVL;
          cntN       = '0;
          strb.goLvl = 1'b1;
        end else begin
          cntN = cnt + 1'b1;
        end
      end
      ST_LVL: begin
        if (cnt == LVL_LAST) begin
          strb.sample = 1'b1;
          cntN        = '0;
          if (col == LAST_COL) begin
            stateN    = ST_PARK;
            strb.park = 1'b1;
          end else begin
            stateN        = ST_DIR;
            colN          = col + 1'b1;
            strb.goDir    = 1'b1;
            strb.driveCol = col + 1'b1;
          end
        end else begin
          cntN = cnt + 1'b1;
        end
      end
      ST_PARK: begin
        stateN       = ST_IDLE;
        strb.restore = 1'b1;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_comb begin
    if (startNow)                                    pendingN = 1'b0;
    else if (state != ST_IDLE && enable && request)  pendingN = 1'b1;
    else                                             pendingN = pending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      col     <= '0;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      state   <= stateN;
      col     <= colN;
      cnt     <= cntN;
      pending <= pendingN;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/kbs_datapath.sv
module kbs_datapath
  import kbs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  scanStrobe_t        strb,
  input  logic [BANK_W-1:0]  senseLo,
  input  logic [BANK_W-1:0]  senseHi,
  output logic [BANK_W-1:0]  oeA,
  output logic [BANK_W-1:0]  lvlA,
  output logic [BANK_W-1:0]  oeB,
  output logic [BANK_W-1:0]  lvlB,
  output logic [SENSE_W-1:0] keyWord,
  output logic [COL_W-1:0]   keyCol,
  output logic               keyValid
);

  lineSel_t sel;
  assign sel = colToLine(strb.driveCol);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [BANK_W-1:0] MASK = (b == 0) ? SCAN_MASK_A : SCAN_MASK_B;
    logic [BANK_W-1:0] selHot;
    logic [BANK_W-1:0] oeR;
    logic [BANK_W-1:0] lvlR;

    always_comb begin
      selHot = '0;
      if (sel.bank == 1'(b)) selHot[sel.line] = 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        oeR  <= MASK;
        lvlR <= '1;
      end else begin
        if (strb.goDir)        oeR <= selHot;
        else if (strb.restore) oeR <= MASK;
        if (strb.goLvl)        lvlR <= ~selHot;
        else if (strb.park)    lvlR <= '1;
      end
    end
  end

  assign oeA  = g_bank[0].oeR;
  assign lvlA = g_bank[0].lvlR;
  assign oeB  = g_bank[1].oeR;
  assign lvlB = g_bank[1].lvlR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyWord  <= '1;
      keyCol   <= '0;
      keyValid <= 1'b0;
    end else begin
      keyValid <= strb.sample;
      if (strb.sample) begin
        keyWord <= {senseHi, senseLo};
        keyCol  <= strb.sampCol;
      end
    end
  end

endmodule

// File: rtl/kbd_scan_seq.sv
module kbd_scan_seq
  import kbs_pkg::*;
#(
  parameter int CLK_MHZ = 200,
  parameter int DIR_US  = 5,
  parameter int LVL_US  = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        tick,
  input  logic        pollReq,
  input  logic [7:0]  senseLo,
  input  logic [7:0]  senseHi,
  output logic [7:0]  oeBankA,
  output logic [7:0]  lvlBankA,
  output logic [7:0]  oeBankB,
  output logic [7:0]  lvlBankB,
  output logic [15:0] keyWord,
  output logic [2:0]  keyCol,
  output logic        keyValid,
  output logic        busy
);

  localparam int DIR_CYC = CLK_MHZ * DIR_US;
  localparam int LVL_CYC = CLK_MHZ * LVL_US;

  scanStrobe_t strb;

  kbs_ctrl #(
    .DIR_CYC(DIR_CYC),
    .LVL_CYC(LVL_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .tick   (tick),
    .pollReq(pollReq),
    .busy   (busy),
    .strb   (strb)
  );

  kbs_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .senseLo (senseLo),
    .senseHi (senseHi),
    .oeA     (oeBankA),
    .lvlA    (lvlBankA),
    .oeB     (oeBankB),
    .lvlB    (lvlBankB),
    .keyWord (keyWord),
    .keyCol  (keyCol),
    .keyValid(keyValid)
  );

endmodule

// File: rtl/kbd_scan_seq_chk.sv
module kbd_scan_seq_chk
  import kbs_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [7:0] oeBankA,
  input logic [7:0] lvlBankA,
  input logic [7:0] oeBankB,
  input logic [7:0] lvlBankB,
  input logic       keyValid,
  input logic       busy
);

  a_r1_valid_in_pass: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |-> busy);

  a_r3_one_driver: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(oeBankA) + $countones(oeBankB)) == 1);

  a_r3_dir_keeps_levels: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && ($past(oeBankA) != oeBankA || $past(oeBankB) != oeBankB))
      |-> ($stable(lvlBankA) && $stable(lvlBankB)));

  a_r4_single_low: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(~lvlBankA) + $countones(~lvlBankB)) <= 1);

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> !keyValid);

  a_r6_park_before_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(lvlBankA) == 8'hFF && $past(lvlBankB) == 8'hFF));

  a_r7_enabled_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(enable));

  a_r8_idle_pattern: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (oeBankA == SCAN_MASK_A && oeBankB == SCAN_MASK_B &&
               lvlBankA == 8'hFF && lvlBankB == 8'hFF));

  a_r10_unused_released: assert property (@(posedge clk) disable iff (!rstN)
    ((oeBankA & ~SCAN_MASK_A) == 8'h00 && (oeBankB & ~SCAN_MASK_B) == 8'h00 &&
     (lvlBankA | SCAN_MASK_A) == 8'hFF && (lvlBankB | SCAN_MASK_B) == 8'hFF));

endmodule

bind kbd_scan_seq kbd_scan_seq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .oeBankA (oeBankA),
  .lvlBankA(lvlBankA),
  .oeBankB (oeBankB),
  .lvlBankB(lvlBankB),
  .keyValid(keyValid),
  .busy    (busy)
);

// File: tb/kbd_scan_seq_bench.sv
module kbd_scan_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_MHZ = 2;
  localparam int DCYC    = CLK_MHZ * 5;
  localparam int LCYC    = CLK_MHZ * 50;
  localparam int STEP    = DCYC + LCYC;
  localparam int PASS_T  = 8 * STEP + 1;

  logic clk = 1'b0;
  logic rstN, enable, tick, pollReq;
  logic [7:0] senseLo, senseHi, oeBankA, lvlBankA, oeBankB, lvlBankB;
  logic [15:0] keyWord;
  logic [2:0] keyCol;
  logic keyValid, busy;

  always #2.5 clk = ~clk;

  kbd_scan_seq #(.CLK_MHZ(CLK_MHZ)) u_kbd_scan_seq (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick), .pollReq(pollReq),
    .senseLo(senseLo), .senseHi(senseHi),
    .oeBankA(oeBankA), .lvlBankA(lvlBankA), .oeBankB(oeBankB), .lvlBankB(lvlBankB),
    .keyWord(keyWord), .keyCol(keyCol), .keyValid(keyValid), .busy(busy)
  );

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench copy of the wiring order: bit index in {bankB, bankA}
  function automatic int lineIdx(input int c);
    case (c)
      0: return 1;
      1: return 5;
      2: return 9;
      3: return 14;
      4: return 15;
      5: return 11;
      6: return 8;
      default: return 7;
    endcase
  endfunction

  logic [15:0] matrix [8];
  wire  [15:0] oeAll  = {oeBankB, oeBankA};
  wire  [15:0] lvlAll = {lvlBankB, lvlBankA};
  logic [15:0] senseWord;

  always_comb begin
    senseWord = 16'hFFFF;
    for (int c = 0; c < 8; c++)
      if (oeAll[lineIdx(c)] && !lvlAll[lineIdx(c)]) senseWord = matrix[c];
  end
  assign senseLo = senseWord[7:0];
  assign senseHi = senseWord[15:8];

  // pass monitor
  int tCnt = 0, gap = 0, lastGap = 0, passes = 0, validSeen = 0;
  bit passBad = 1'b0;
  int badT = 0;
  logic [47:0] badAct, badExp;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        logic [15:0] eOe, eLvl;
        bit eValid;
        int k, r;
        if (tCnt == 0) lastGap = gap;
        tCnt++;
        k = (tCnt - 1) / STEP;
        r = (tCnt - 1) % STEP;
        if (tCnt >= PASS_T) begin
          eOe  = 16'(1) << lineIdx(7);
          eLvl = 16'hFFFF;
        end else begin
          eOe = 16'(1) << lineIdx(k);
          if (r >= DCYC)   eLvl = ~(16'(1) << lineIdx(k));
          else if (k == 0) eLvl = 16'hFFFF;
          else             eLvl = ~(16'(1) << lineIdx(k - 1));
        end
        eValid = (tCnt > 1) && (tCnt % STEP == 1);
        if (!passBad && (oeAll !== eOe || lvlAll !== eLvl || keyValid !== eValid)) begin
          passBad = 1'b1;
          badT    = tCnt;
          badAct  = {oeAll, lvlAll, 15'd0, keyValid};
          badExp  = {eOe, eLvl, 15'd0, eValid};
        end
        if (keyValid) begin
          check(keyCol == 3'(validSeen), "R1 column order", 32'(keyCol), 32'(validSeen));
          check(keyWord == matrix[validSeen[2:0]], "R5 captured word",
                32'(keyWord), 32'(matrix[validSeen[2:0]]));
          validSeen++;
        end
      end else begin
        if (tCnt != 0) begin
          if (passBad) $display("  mismatch at pass cycle %0d", badT);
          check(!passBad, "R2 R3 R4 R6 line pattern",
                passBad ? badAct[31:0] : 32'd0, passBad ? badExp[31:0] : 32'd0);
          check(validSeen == 8 && tCnt == PASS_T, "R1 R8 pass length",
                32'(tCnt * 16 + validSeen), 32'(PASS_T * 16 + 8));
          passes++;
          tCnt = 0; validSeen = 0; passBad = 1'b0; gap = 0;
        end
        gap++;
      end
    end
  end

  task automatic pulse(input bit usePoll);
    @(negedge clk);
    if (usePoll) pollReq = 1'b1; else tick = 1'b1;
    @(negedge clk);
    pollReq = 1'b0; tick = 1'b0;
  endtask

  task automatic waitPasses(input int n);
    wait (passes >= n);
    @(negedge clk);
  endtask

  task automatic newMatrix();
    for (int c = 0; c < 8; c++) matrix[c] = 16'($urandom);
  endtask

  task automatic checkIdle(input string req);
    check(busy == 1'b0 && oeAll == 16'hCBA2 && lvlAll == 16'hFFFF, req,
          {oeAll, lvlAll}, {16'hCBA2, 16'hFFFF});
  endtask

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; enable = 1'b0; tick = 1'b0; pollReq = 1'b0;
    for (int c = 0; c < 8; c++) matrix[c] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(keyValid == 1'b0 && keyWord == 16'hFFFF && keyCol == 3'd0, "R11 reset outputs",
          {keyValid, 12'd0, keyCol, keyWord}, {16'd0, 16'hFFFF});
    checkIdle("R11 R10 reset lines");

    // requests while disabled are dropped (R7)
    pulse(1'b0);
    pulse(1'b1);
    repeat (30) @(negedge clk);
    check(passes == 0 && busy == 1'b0, "R7 no start when disabled", 32'(passes), 0);
    enable = 1'b1;
    repeat (30) @(negedge clk);
    check(passes == 0 && busy == 1'b0, "R7 dropped request not kept", 32'(passes), 0);

    // directed extremes: all pressed / none pressed
    newMatrix();
    matrix[0] = 16'h0000;
    matrix[7] = 16'hFFFF;
    pulse(1'b0);
    waitPasses(1);
    checkIdle("R8 R10 idle after tick pass");

    newMatrix();
    pulse(1'b1);
    waitPasses(2);
    checkIdle("R8 idle after poll pass");

    // several requests during a pass give one extra pass (R9)
    newMatrix();
    pulse(1'b0);
    repeat (300) @(negedge clk);
    pulse(1'b1);
    repeat (50) @(negedge clk);
    pulse(1'b0);
    waitPasses(4);
    check(lastGap == 1, "R9 one-cycle idle gap", 32'(lastGap), 1);
    repeat (1200) @(negedge clk);
    check(passes == 4, "R9 only one extra pass", 32'(passes), 4);

    // request in the parked cycle (R9)
    newMatrix();
    pulse(1'b0);
    repeat (PASS_T - 1) @(negedge clk);
    pollReq = 1'b1;
    @(negedge clk);
    pollReq = 1'b0;
    waitPasses(6);
    check(lastGap == 1, "R9 request in parked cycle", 32'(lastGap), 1);
    repeat (1200) @(negedge clk);
    check(passes == 6, "R9 parked request single pass", 32'(passes), 6);

    // disable during a pass: it completes, nothing new starts (R7)
    newMatrix();
    pulse(1'b1);
    repeat (200) @(negedge clk);
    enable = 1'b0;
    waitPasses(7);
    pulse(1'b0);
    repeat (50) @(negedge clk);
    check(passes == 7 && busy == 1'b0, "R7 disabled after running pass", 32'(passes), 7);
    enable = 1'b1;

    // random triggers and matrices
    for (int i = 0; i < 4; i++) begin
      newMatrix();
      repeat ($urandom_range(1, 40)) @(negedge clk);
      pulse(1'($urandom_range(0, 1)));
      waitPasses(8 + i);
      checkIdle("R8 idle after random pass");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule